// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block sits on a two-wire serial bus as a slave and presents a 128-byte storage array in the manner of a small serial EEPROM. It samples SCL and SDA with the system clock and tracks START and STOP conditions at all times. After a START it takes in a control byte. If that byte carries the fixed device code, the slave acknowledges it and then follows one of two paths:

- **Write path:** it accepts a word address and then data bytes.
- **Read path:** it streams bytes out from the current address.

The pad is open-drain. The block reads the resolved SDA level on one input and pulls the line low through an output-enable.

A STOP that closes a transfer in which data was written starts a programming interval. This interval is a count of system clock cycles. While it runs, the slave does not acknowledge its control byte, so a master can poll the slave until it answers. A START that arrives in the middle of any byte abandons the transfer and begins a new control byte. The word address is kept across this repeated start, so a master can write an address and then switch to reading.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins control-byte reception from any state. A STOP (SDA rises while SCL is high) returns the slave to idle with `sda_oe` low.
- R2: A control byte is acknowledged when its upper four bits, received MSB first, equal 4'b1010 and no programming interval is running. Bits 3..1 are ignored. Bit 0 set to 1 selects a read and set to 0 selects a write.
- R3: After a control byte with any other device code, the slave keeps `sda_oe` low until the next START, whatever bytes follow.
- R4: An acknowledge drives `sda_oe` high from the SCL falling edge that ends the eighth bit until the SCL falling edge that ends the ninth clock. `sda_oe` never changes while SCL stays high.
- R5: In a write, the byte after the control byte sets the word address from its low 7 bits; its MSB is ignored. Each further byte is acknowledged and stored at the word address. The address then increments, wrapping from 127 to 0.
- R6: A STOP after at least one stored data byte starts a programming interval of `PROG_CYCLES` clock cycles, during which control bytes are not acknowledged. A STOP after only an address byte starts no interval.
- R7: In a read, the slave drives the byte at the word address MSB first, one bit per SCL low phase, and increments the address. After a master acknowledge (SDA low on the ninth clock) it sends the next byte. After SDA high on the ninth clock it releases SDA and goes idle.
- R8: A START in the middle of a byte abandons the partial byte without storing it and restarts control-byte reception. The word address is kept, so a repeated start into a read returns data from the address just written.
- R9: After reset `sda_oe` is low, every array byte is 0, the word address is 0 and no programming interval runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved bus data level |
| sda_oe | output | 1 | When high, pulls the data line low |

## Verification
The hardest case to reach is refusal during the programming interval. It needs a STOP following a stored byte and then, well inside `PROG_CYCLES`, a fresh control byte. The bench therefore uses a short interval and issues the poll straight after the write STOP. After a long pause it polls again to confirm that the acknowledge returns. The repeated-start case is reached by cutting a data byte off after four bits. The bench then reads back to show that neither the partial byte nor the address changed.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 7,
  parameter int PROG_CYCLES = 2000,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} kind_t;

  state_t st;
  kind_t kind;
  logic scl_q, scl_p, sda_q, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic [ADDR_W-1:0] addr;
  logic rw, wrote, mack;
  logic [CNT_W-1:0] prog_cnt;
  logic [7:0] mem [DEPTH];

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;
  wire busy      = prog_cnt != '0;
  wire [7:0] rd_byte = mem[addr];
  wire byte_end  = scl_fall && bitcnt == 4'd8;
  wire mem_we    = st == S_RX && kind == K_DATA && byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (mem_we) begin
      mem[addr] <= shreg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_p <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
      st <= S_IDLE; kind <= K_CTRL; bitcnt <= '0;
      shreg <= '0; txsh <= '0; addr <= '0;
      rw <= 1'b0; wrote <= 1'b0; mack <= 1'b0;
      prog_cnt <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q;
      sda_q <= sda_i; sda_p <= sda_q;
      if (busy) prog_cnt <= prog_cnt - 1'b1;
      if (stop_det) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        if (wrote) prog_cnt <= CNT_W'(PROG_CYCLES);
        wrote <= 1'b0;
      end else if (start_det) begin
        st <= S_RX;
        kind <= K_CTRL;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_end) begin
              bitcnt <= '0;
              case (kind)
                K_CTRL: begin
                  if (shreg[7:4] == DEV_CODE && !busy) begin
                    rw <= shreg[0];
                    sda_oe <= 1'b1;
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_ADDR: begin
                  addr <= shreg[ADDR_W-1:0];
                  sda_oe <= 1'b1;
                  st <= S_ACK;
                end
                default: begin
                  addr <= addr + 1'b1;
                  wrote <= 1'b1;
                  sda_oe <= 1'b1;
                  st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == K_CTRL && rw) begin
                txsh <= rd_byte;
                sda_oe <= ~rd_byte[7];
                addr <= addr + 1'b1;
                st <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st <= S_RX;
                kind <= (kind == K_CTRL) ? K_ADDR : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st <= S_MACK;
              end else begin
                txsh <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_q;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                txsh <= rd_byte;
                sda_oe <= ~rd_byte[7];
                addr <= addr + 1'b1;
                st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_steady_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_p) |=> $stable(sda_oe));
  assert_release_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && scl_fall && !(kind == K_CTRL && rw)) |=> !sda_oe);
  assert_no_ctrl_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && kind == K_CTRL) |-> !busy);
  assert_prog_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
  assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));
  assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_RX && kind == K_CTRL && bitcnt == 4'd0 && !sda_oe));
  assert_nack_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_fall && !mack) |=> (st == S_IDLE && !sda_oe));
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int PROG = 300;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave #(.ADDR_W(7), .PROG_CYCLES(PROG), .DEV_CODE(4'b1010)) u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic chk_en = 1'b0, exp_oe = 1'b0;
  string req = "R9";
  logic [7:0] mem_m [128];
  int addr_m = 0;
  logic wrote_m = 1'b0;
  int stop_cyc = -100000;

  always @(negedge clk) if (chk_en) begin
    checks++;
    if (sda_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: sda_oe=%0b expected %0b (cycle %0d)", req, sda_oe, exp_oe, cyc);
    end
  end

  function automatic bit busy_m();
    return (cyc - stop_cyc) < PROG;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic md, input logic drv, output logic seen);
    m_sda = md; chk_en = 0; tick(4);
    exp_oe = drv; chk_en = 1; tick(1);
    scl = 1; tick(4);
    seen = sda_bus;
    scl = 0; chk_en = 0;
  endtask

  task automatic do_start();
    chk_en = 0; m_sda = 1; tick(3); scl = 1; tick(3); m_sda = 0; tick(3); scl = 0; tick(3);
  endtask

  task automatic do_stop();
    chk_en = 0; m_sda = 0; tick(3); scl = 1; tick(3); m_sda = 1;
    if (wrote_m) begin stop_cyc = cyc; wrote_m = 0; end
    tick(3);
    req = "R1"; exp_oe = 0; chk_en = 1; tick(3); chk_en = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string r);
    logic s;
    req = r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
    clk_bit(1'b1, exp_ack, s);
  endtask

  task automatic ctrl(input logic [7:0] c, input string r);
    send_byte(c, (c[7:4] == 4'b1010) && !busy_m(), r);
  endtask

  task automatic set_addr(input logic [7:0] a);
    send_byte(a, 1'b1, "R5");
    addr_m = a & 8'h7f;
  endtask

  task automatic wr_data(input logic [7:0] d);
    send_byte(d, 1'b1, "R5");
    mem_m[addr_m] = d;
    addr_m = (addr_m + 1) % 128;
    wrote_m = 1;
  endtask

  task automatic rd_data(input logic m_ack, input string r);
    logic s;
    logic [7:0] b, e;
    e = mem_m[addr_m];
    req = r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~e[i], s);
      b[i] = s;
    end
    addr_m = (addr_m + 1) % 128;
    clk_bit(~m_ack, 1'b0, s);
    checks++;
    if (b !== e) begin
      errors++;
      $display("FAIL %s: read byte %02h expected %02h", r, b, e);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog (all): run still active, expected completion");
    finish_run();
  end

  initial begin
    logic s;
    for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
    tick(5);
    checks++;
    if (sda_oe !== 1'b0) begin errors++; $display("FAIL R9: sda_oe=%0b expected 0 in reset", sda_oe); end
    rst_n = 1; tick(5);

    // R9: array cleared, address 0
    do_start(); ctrl(8'hA1, "R2"); rd_data(1'b0, "R9"); do_stop();

    // R5 R2: write three bytes from address 5
    do_start(); ctrl(8'hA0, "R2"); set_addr(8'h05);
    wr_data(8'h3C); wr_data(8'hA5); wr_data(8'hFF); do_stop();

    // R6: poll inside programming interval is refused
    do_start(); ctrl(8'hA1, "R6"); do_stop();
    tick(PROG + 100);

    // R2 R5 R8 R7: select bits ignored, address MSB ignored, repeated start into read
    do_start(); ctrl(8'hAE, "R2"); set_addr(8'h85);
    do_start(); ctrl(8'hA3, "R8");
    rd_data(1'b1, "R7"); rd_data(1'b1, "R7"); rd_data(1'b0, "R7");
    clk_bit(1'b1, 1'b0, s);
    do_stop();

    // R6: stop after only an address, then a control byte is acknowledged at once
    do_start(); ctrl(8'hA0, "R6"); set_addr(8'h20); do_stop();
    do_start(); ctrl(8'hA0, "R6"); set_addr(8'h21); do_stop();

    // R3: wrong device code, following bytes ignored
    do_start(); ctrl(8'hB0, "R3"); send_byte(8'h00, 1'b0, "R3"); send_byte(8'h55, 1'b0, "R3"); do_stop();
    do_start(); ctrl(8'h50, "R3"); do_stop();

    // R5: address wraps 127 -> 0
    do_start(); ctrl(8'hA0, "R5"); set_addr(8'h7F); wr_data(8'h11); wr_data(8'h22); do_stop();
    tick(PROG + 100);
    do_start(); ctrl(8'hA0, "R5"); set_addr(8'h7F);
    do_start(); ctrl(8'hA1, "R5"); rd_data(1'b1, "R5"); rd_data(1'b0, "R5"); do_stop();

    // R8: start inside a data byte abandons it
    do_start(); ctrl(8'hA0, "R8"); set_addr(8'h06);
    req = "R8";
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, s);
    do_start(); ctrl(8'hA1, "R8"); rd_data(1'b0, "R8"); do_stop();
    tick(20);
    checks++;
    if (sda_oe !== 1'b0) begin errors++; $display("FAIL R1: sda_oe=%0b expected 0 when idle", sda_oe); end

    finish_run();
  end
endmodule